// File: doc/BRIEF.md
# Remote DMA Host Port

This block is the host-side path into the packet memory of a small network controller. A processor reaches it through an 8-bit register bus with a 4-bit offset, a chip select and separate read and write strobes. The processor loads a start address and a byte count, then writes a command that opens a remote read or a remote write. From then on, every access to a separate 16-bit data port moves one byte or one word between the host and an on-chip byte RAM. Each access also advances the current address and lowers the remaining count.

When the count reaches zero the block raises a completion flag in an interrupt status register. These status bits are cleared by writing ones to them. An abort code in the command ends a transfer at once and does not raise the flag. A page field in the command register hides every other register when it is not zero. A configuration bit selects word-wide data-port accesses. In that mode the byte count is still kept in bytes.

The transfer engine is a three-state machine:
- `ENG_IDLE` goes to `ENG_READ` on the read code, or to `ENG_WRITE` on the write code, but only when the count is not zero.
- `ENG_READ` and `ENG_WRITE` return to `ENG_IDLE` on the access that uses up the count. This transition is called the finish transition.
- `ENG_READ` and `ENG_WRITE` also return to `ENG_IDLE` when the abort code is written. This transition is called the abort transition.

Top module: `rdma_port`

## Requirements
- R1: After reset the registers read as follows: command 0x21, status 0x80, ring start page 0x20, ring stop page 0x40, data configuration 0x00, and address and count all zero.
- R2: Offsets 4 and 5 write the low and high bytes of the start address. Offsets 6 and 7 write the low and high bytes of the byte count. Reading the same offsets returns the current address and the remaining count.
- R3: The command register (offset 0) has this layout: bit 0 stop, bit 1 start, bit 2 transmit request, bits 5:3 remote field, bits 7:6 page. In the remote field, 001 opens a read, 010 opens a write, and any value with bit 5 set aborts. Other values leave the engine as it is. The remote field reads 100 when idle, 001 during a read and 010 during a write.
- R4: In byte mode, each data-port write during a remote write stores dp_wdata[7:0] at the current address. The address then rises by 1 and the count falls by 1.
- R5: In byte mode, each data-port read during a remote read returns the byte at the current address on dp_rdata[7:0], with bits 15:8 zero, one cycle after the strobe.
- R6: With bit 0 of the data configuration register (offset 8) set, each access moves two bytes, little-endian: the low byte goes to the lower address. The address then rises by 2 and the count falls by 2. An access made when only one byte remains moves just the low byte.
- R7: The access that brings the count to zero sets status bit 6 and returns the engine to idle.
- R8: The status register is at offset 3. Writing 1 to a bit clears only that bit. Writing 0xFF clears all pending bits, including the reset bit 7.
- R9: Data-port accesses while no transfer is active are ignored. A write leaves memory and the address unchanged, and a read returns zero.
- R10: Writing the abort code stops a transfer at once, without setting status bit 6. Later data-port accesses are then ignored.
- R11: With a nonzero page, every offset except 0 reads zero and ignores writes. The command register stays reachable on every page.
- R12: A read or write code issued while the count is zero leaves the engine idle and does not set status bit 6.
- R13: The stop, start, transmit-request and page bits of the command register read back as they were last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_cs | input | 1 | Register bus chip select |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data; zero unless chip select and read strobe are both high |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data, valid the cycle after dp_rd |

## Verification
The bench first writes an odd-length byte run and reads it back. This separates the byte path from the word path and shows the address and count moving one step per access. A five-byte word-mode write into a prefilled area shows whether a final single byte lands without disturbing its neighbour. Reading that area back in both widths checks the byte order. Three further patterns tell apart the cases in which the completion flag must stay clear: data-port accesses with no command open, a zero count, and an abort in the middle of a transfer. Paged accesses show whether the page field really hides the other registers.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE
    } eng_state_t;

    localparam logic [3:0] OFF_CMD    = 4'h0;
    localparam logic [3:0] OFF_PSTART = 4'h1;
    localparam logic [3:0] OFF_PSTOP  = 4'h2;
    localparam logic [3:0] OFF_STAT   = 4'h3;
    localparam logic [3:0] OFF_ADR_LO = 4'h4;
    localparam logic [3:0] OFF_ADR_HI = 4'h5;
    localparam logic [3:0] OFF_CNT_LO = 4'h6;
    localparam logic [3:0] OFF_CNT_HI = 4'h7;
    localparam logic [3:0] OFF_DCFG   = 4'h8;

    localparam logic [2:0] RFLD_READ  = 3'b001;
    localparam logic [2:0] RFLD_WRITE = 3'b010;
    localparam logic [2:0] RFLD_IDLE  = 3'b100;

    localparam int STAT_RST_BIT = 7;
    localparam int STAT_DONE_BIT = 6;

    function automatic logic [2:0] field_of(eng_state_t s);
        case (s)
            ENG_READ:  return RFLD_READ;
            ENG_WRITE: return RFLD_WRITE;
            default:   return RFLD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs #(
    parameter logic [7:0] PSTART_RST = 8'h20,
    parameter logic [7:0] PSTOP_RST  = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cmd,
    input  logic       wr_pstart,
    input  logic       wr_pstop,
    input  logic       wr_stat,
    input  logic       wr_dcfg,
    input  logic [7:0] wdata,
    input  logic       done_i,
    output logic [1:0] page,
    output logic       cmd_stp,
    output logic       cmd_sta,
    output logic       cmd_txp,
    output logic [7:0] pstart,
    output logic [7:0] pstop,
    output logic [7:0] dcfg,
    output logic       stat_rst,
    output logic       stat_done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page    <= 2'd0;
            cmd_stp <= 1'b1;
            cmd_sta <= 1'b0;
            cmd_txp <= 1'b0;
            pstart  <= PSTART_RST;
            pstop   <= PSTOP_RST;
            dcfg    <= 8'h00;
        end else begin
            if (wr_cmd) begin
                cmd_stp <= wdata[0];
                cmd_sta <= wdata[1];
                cmd_txp <= wdata[2];
                page    <= wdata[7:6];
            end
            if (wr_pstart) pstart <= wdata;
            if (wr_pstop)  pstop  <= wdata;
            if (wr_dcfg)   dcfg   <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_rst  <= 1'b1;
            stat_done <= 1'b0;
        end else begin
            if (wr_stat && wdata[rdma_pkg::STAT_RST_BIT]) stat_rst <= 1'b0;
            if (done_i)
                stat_done <= 1'b1;
            else if (wr_stat && wdata[rdma_pkg::STAT_DONE_BIT])
                stat_done <= 1'b0;
        end
    end

    // R7
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> stat_done);

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[rdma_pkg::STAT_DONE_BIT] && !done_i) |=> !stat_done);

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              go_rd,
    input  logic              go_wr,
    input  logic              abort,
    input  logic              ld_adr_lo,
    input  logic              ld_adr_hi,
    input  logic              ld_cnt_lo,
    input  logic              ld_cnt_hi,
    input  logic [7:0]        ld_data,
    input  logic              dp_rd,
    input  logic              dp_wr,
    output eng_state_t        state,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remain,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              two_bytes,
    output logic              done
);

    localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);
    localparam logic [CNT_W-1:0]  TWO_C  = CNT_W'(2);

    eng_state_t        nxt;
    logic              cmd_any;
    logic              ld_any;
    logic              acc;
    logic [CNT_W-1:0]  moved;

    assign cmd_any = go_rd | go_wr | abort;
    assign ld_any  = ld_adr_lo | ld_adr_hi | ld_cnt_lo | ld_cnt_hi;

    always_comb begin
        two_bytes = word_mode && (remain != ONE_C);
        moved     = two_bytes ? TWO_C : ONE_C;
        acc_rd    = !cmd_any && (state == ENG_READ)  && dp_rd;
        acc_wr    = !cmd_any && (state == ENG_WRITE) && dp_wr;
        acc       = acc_rd | acc_wr;
        done      = acc && (remain == moved);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE: begin
                if (!abort && remain != '0) begin
                    if (go_rd)      nxt = ENG_READ;
                    else if (go_wr) nxt = ENG_WRITE;
                end
            end
            ENG_READ, ENG_WRITE: begin
                if (abort)                        nxt = ENG_IDLE;
                else if (go_rd && remain != '0)   nxt = ENG_READ;
                else if (go_wr && remain != '0)   nxt = ENG_WRITE;
                else if (go_rd || go_wr)          nxt = ENG_IDLE;
                else if (done)                    nxt = ENG_IDLE;
            end
            default: nxt = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else begin
            if (acc) begin
                cur_addr <= cur_addr + ADDR_W'(moved);
                remain   <= remain - moved;
            end
            if (ld_adr_lo) cur_addr[7:0]        <= ld_data;
            if (ld_adr_hi) cur_addr[ADDR_W-1:8] <= ld_data[ADDR_W-9:0];
            if (ld_cnt_lo) remain[7:0]          <= ld_data;
            if (ld_cnt_hi) remain[CNT_W-1:8]    <= ld_data[CNT_W-9:0];
        end
    end

    // R7
    finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ENG_IDLE));

    // R10
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ENG_IDLE));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE && !cmd_any && !ld_any) |=> ($stable(cur_addr) && $stable(remain)));

    // R4
    count_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ld_any) |=> (remain < $past(remain)));

endmodule

// File: rtl/rdma_mem.sv
module rdma_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          we_hi,
    input  logic [15:0]   wdata,
    input  logic          rd_strobe,
    input  logic          rd_valid,
    input  logic          rd_two,
    output logic [15:0]   rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] addr_nx;

    assign addr_nx = addr + {{(AW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (we)    mem[addr]    <= wdata[7:0];
        if (we_hi) mem[addr_nx] <= wdata[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= 16'h0000;
        else if (rd_strobe) begin
            if (rd_valid)
                rdata <= {(rd_two ? mem[addr_nx] : 8'h00), mem[addr]};
            else
                rdata <= 16'h0000;
        end
    end

endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdma_pkg::*;
#(
    parameter int         MEM_AW     = 10,
    parameter logic [7:0] PSTART_RST = 8'h20,
    parameter logic [7:0] PSTOP_RST  = 8'h40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_cs,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic [15:0] dp_wdata,
    output logic [15:0] dp_rdata
);

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;

    logic              wr_en, page0;
    logic              wr_cmd, wr_pstart, wr_pstop, wr_stat, wr_dcfg;
    logic              go_rd, go_wr, abort;
    logic [1:0]        page;
    logic              cmd_stp, cmd_sta, cmd_txp;
    logic [7:0]        pstart, pstop, dcfg;
    logic              stat_rst, stat_done;
    eng_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic              acc_rd, acc_wr, two_bytes, done;

    assign wr_en     = reg_cs && reg_wr;
    assign page0     = (page == 2'd0);
    assign wr_cmd    = wr_en && (reg_addr == OFF_CMD);
    assign wr_pstart = wr_en && page0 && (reg_addr == OFF_PSTART);
    assign wr_pstop  = wr_en && page0 && (reg_addr == OFF_PSTOP);
    assign wr_stat   = wr_en && page0 && (reg_addr == OFF_STAT);
    assign wr_dcfg   = wr_en && page0 && (reg_addr == OFF_DCFG);

    assign abort = wr_cmd && reg_wdata[5];
    assign go_rd = wr_cmd && (reg_wdata[5:3] == RFLD_READ);
    assign go_wr = wr_cmd && (reg_wdata[5:3] == RFLD_WRITE);

    rdma_regs #(
        .PSTART_RST(PSTART_RST),
        .PSTOP_RST (PSTOP_RST)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (wr_cmd),
        .wr_pstart(wr_pstart),
        .wr_pstop (wr_pstop),
        .wr_stat  (wr_stat),
        .wr_dcfg  (wr_dcfg),
        .wdata    (reg_wdata),
        .done_i   (done),
        .page     (page),
        .cmd_stp  (cmd_stp),
        .cmd_sta  (cmd_sta),
        .cmd_txp  (cmd_txp),
        .pstart   (pstart),
        .pstop    (pstop),
        .dcfg     (dcfg),
        .stat_rst (stat_rst),
        .stat_done(stat_done)
    );

    rdma_engine #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_mode(dcfg[0]),
        .go_rd    (go_rd),
        .go_wr    (go_wr),
        .abort    (abort),
        .ld_adr_lo(wr_en && page0 && (reg_addr == OFF_ADR_LO)),
        .ld_adr_hi(wr_en && page0 && (reg_addr == OFF_ADR_HI)),
        .ld_cnt_lo(wr_en && page0 && (reg_addr == OFF_CNT_LO)),
        .ld_cnt_hi(wr_en && page0 && (reg_addr == OFF_CNT_HI)),
        .ld_data  (reg_wdata),
        .dp_rd    (dp_rd),
        .dp_wr    (dp_wr),
        .state    (state),
        .cur_addr (cur_addr),
        .remain   (remain),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .two_bytes(two_bytes),
        .done     (done)
    );

    rdma_mem #(
        .AW(MEM_AW)
    ) mem_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cur_addr[MEM_AW-1:0]),
        .we       (acc_wr),
        .we_hi    (acc_wr && two_bytes),
        .wdata    (dp_wdata),
        .rd_strobe(dp_rd),
        .rd_valid (acc_rd),
        .rd_two   (two_bytes),
        .rdata    (dp_rdata)
    );

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_cs && reg_rd) begin
            if (reg_addr == OFF_CMD)
                reg_rdata = {page, field_of(state), cmd_txp, cmd_sta, cmd_stp};
            else if (page0) begin
                case (reg_addr)
                    OFF_PSTART: reg_rdata = pstart;
                    OFF_PSTOP:  reg_rdata = pstop;
                    OFF_STAT:   reg_rdata = {stat_rst, stat_done, 6'b0};
                    OFF_ADR_LO: reg_rdata = cur_addr[7:0];
                    OFF_ADR_HI: reg_rdata = cur_addr[15:8];
                    OFF_CNT_LO: reg_rdata = remain[7:0];
                    OFF_CNT_HI: reg_rdata = remain[15:8];
                    OFF_DCFG:   reg_rdata = dcfg;
                    default:    reg_rdata = 8'h00;
                endcase
            end
        end
    end

endmodule

// File: tb/rdma_port_tb.sv
module rdma_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_cs = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0, dp_wr = 1'b0;
    logic [15:0] dp_wdata = 16'h0000;
    logic [15:0] dp_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rdma_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_cs(reg_cs), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rw(input logic [3:0] off, input logic [7:0] d);
        reg_cs = 1'b1; reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_cs = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [3:0] off, input logic [7:0] exp);
        reg_cs = 1'b1; reg_rd = 1'b1; reg_addr = off;
        #1;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
        @(negedge clk);
        reg_cs = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic dpw(input logic [15:0] d);
        dp_wr = 1'b1; dp_wdata = d;
        @(negedge clk);
        dp_wr = 1'b0;
    endtask

    task automatic dpr(input string req, input logic [15:0] exp);
        dp_rd = 1'b1;
        @(negedge clk);
        dp_rd = 1'b0;
        chk(req, dp_rdata, exp);
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] n);
        rw(4'h4, a[7:0]); rw(4'h5, a[15:8]);
        rw(4'h6, n[7:0]); rw(4'h7, n[15:8]);
    endtask

    task automatic t_reset;
        rchk("R1 cmd", 4'h0, 8'h21);
        rchk("R1 stat", 4'h3, 8'h80);
        rchk("R1 pstart", 4'h1, 8'h20);
        rchk("R1 pstop", 4'h2, 8'h40);
        rchk("R1 dcfg", 4'h8, 8'h00);
        rchk("R1 adr_lo", 4'h4, 8'h00);
        rchk("R1 cnt_hi", 4'h7, 8'h00);
    endtask

    task automatic t_byte_write;
        rw(4'h8, 8'h00);
        setup(16'h2000, 16'd5);
        rw(4'h0, 8'h12);
        rchk("R3 write code shown", 4'h0, 8'h12);
        dpw(16'h00A1); dpw(16'h00B2);
        rchk("R2 adr_lo", 4'h4, 8'h02);
        rchk("R2 adr_hi", 4'h5, 8'h20);
        rchk("R4 count", 4'h6, 8'h03);
        dpw(16'h00C3); dpw(16'h00D4); dpw(16'h00E5);
        rchk("R7 stat done", 4'h3, 8'hC0);
        rchk("R7 cmd idle", 4'h0, 8'h22);
        rchk("R4 count zero", 4'h6, 8'h00);
        rw(4'h3, 8'h40);
        rchk("R8 clear only done", 4'h3, 8'h80);
    endtask

    task automatic t_byte_read;
        setup(16'h2000, 16'd5);
        rw(4'h0, 8'h0A);
        rchk("R3 read code shown", 4'h0, 8'h0A);
        dpr("R5 b0", 16'h00A1);
        dpr("R5 b1", 16'h00B2);
        dpr("R5 b2", 16'h00C3);
        dpr("R5 b3", 16'h00D4);
        dpr("R5 b4", 16'h00E5);
        rchk("R7 read done", 4'h3, 8'hC0);
        rw(4'h3, 8'h40);
    endtask

    task automatic t_ignored;
        dpr("R9 idle read zero", 16'h0000);
        setup(16'h2000, 16'd1);
        dpw(16'h0055);
        rchk("R9 address held", 4'h4, 8'h00);
        rchk("R9 count held", 4'h6, 8'h01);
        rw(4'h0, 8'h0A);
        dpr("R9 memory untouched", 16'h00A1);
        rw(4'h3, 8'h40);
    endtask

    task automatic t_zero;
        setup(16'h2000, 16'd0);
        rw(4'h0, 8'h12);
        rchk("R12 stays idle", 4'h0, 8'h22);
        rchk("R12 no done", 4'h3, 8'h80);
        setup(16'h2000, 16'd2);
        rw(4'h0, 8'h1A);
        rchk("R3 code 011 no effect", 4'h0, 8'h22);
    endtask

    task automatic t_abort;
        rw(4'h3, 8'hFF);
        rchk("R8 clear all", 4'h3, 8'h00);
        setup(16'h2000, 16'd4);
        rw(4'h0, 8'h0A);
        dpr("R5 before abort", 16'h00A1);
        rw(4'h0, 8'h22);
        rchk("R10 cmd idle", 4'h0, 8'h22);
        rchk("R10 no done", 4'h3, 8'h00);
        dpr("R10 read ignored", 16'h0000);
        rchk("R10 addr", 4'h4, 8'h01);
        rchk("R10 count", 4'h6, 8'h03);
    endtask

    task automatic t_word;
        rw(4'h8, 8'h00);
        setup(16'h4000, 16'd6);
        rw(4'h0, 8'h12);
        for (int i = 0; i < 6; i++) dpw(16'h00EE);
        rw(4'h3, 8'h40);
        rw(4'h8, 8'h01);
        setup(16'h4000, 16'd5);
        rw(4'h0, 8'h12);
        dpw(16'h2211);
        rchk("R6 addr +2", 4'h4, 8'h02);
        rchk("R6 count -2", 4'h6, 8'h03);
        dpw(16'h4433);
        dpw(16'h6655);
        rchk("R6 last single addr", 4'h4, 8'h05);
        rchk("R6 done", 4'h3, 8'h40);
        rw(4'h3, 8'h40);
        setup(16'h4000, 16'd4);
        rw(4'h0, 8'h0A);
        dpr("R6 word read 0", 16'h2211);
        dpr("R6 word read 1", 16'h4433);
        rw(4'h8, 8'h00);
        setup(16'h4000, 16'd6);
        rw(4'h0, 8'h0A);
        dpr("R6 byte 0", 16'h0011);
        dpr("R6 byte 1", 16'h0022);
        dpr("R6 byte 2", 16'h0033);
        dpr("R6 byte 3", 16'h0044);
        dpr("R6 byte 4", 16'h0055);
        dpr("R6 neighbour kept", 16'h00EE);
    endtask

    task automatic t_page;
        rw(4'h0, 8'h61);
        rchk("R13 page readback", 4'h0, 8'h61);
        rchk("R11 hidden read", 4'h1, 8'h00);
        rw(4'h1, 8'h99);
        rw(4'h0, 8'h21);
        rchk("R11 write ignored", 4'h1, 8'h20);
        rw(4'h0, 8'h26);
        rchk("R13 txp sta readback", 4'h0, 8'h26);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_byte_read();
        t_ignored();
        t_zero();
        t_abort();
        t_word();
        t_page();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule